// File: doc/BRIEF.md
# Sampling Converter Serial Read-Out Port

This block is the digital read-out side of a 16-bit sampling converter that is started and selected by one select line. A rising edge on the select line takes a sample and starts a conversion. The conversion runs for a fixed number of internal clock cycles, and the select line has no effect on it while it runs. When the conversion ends, the result word from a stand-in conversion engine is captured. The word is then shifted out, MSB first, on falling edges of a host-driven serial clock.

Two read-out options are chosen with a mode input. In the plain option, the data line is driven on a falling edge of select after the conversion. In the three-wire option, the line is driven low as a busy marker at the end of the conversion, provided select is low at that point. In both options the line is released after a fixed number of serial-clock falling edges, or earlier when select rises. The three-state data line is shown as a data bit plus an output enable. All inputs are sampled on the internal clock `clk`, and edges are found by comparing each sample with the previous one.

Top module: `adc_serial_port`

## Requirements
- R1: A rising edge of select, taken while no conversion runs, starts a conversion that ends at the CONV_CYCLES-th clock edge after the start edge. The output enable is low during the conversion. The done flag is cleared at the start edge and set at the end edge.
- R2: Rising or falling edges of select during a conversion neither restart it nor change the cycle in which it ends.
- R3: In three-wire mode (mode input = 1), if select is low at the end edge, the output enable goes high with data 0 in the cycle after that edge.
- R4: In three-wire mode, serial-clock falling edge k (k = 1 to 16) after the busy marker drives result bit 16-k, so the first edge gives bit 15. Falling edge 17 releases the output.
- R5: In plain mode (mode input = 0), a falling edge of select after a conversion has ended drives result bit 15. Serial-clock falling edges k = 1 to 15 after that drive bit 15-k, and falling edge 16 releases the output.
- R6: A rising edge of select while the output is driven releases the output in the next cycle and starts a new conversion.
- R7: Serial-clock falling edges are ignored while select is high or while a conversion runs, including the edge at which it ends. Ignored edges do not advance the bit position.
- R8: In three-wire mode, if select is high at the end edge, no busy marker is driven. The output stays released through later select and serial-clock activity until the next conversion.
- R9: A serial-clock edge is detected once per level change. Holding the serial clock low for several cycles advances the data by exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; drives conversion timing and input sampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_sel_i | input | 1 | Conversion start on its rising edge; also acts as the select line |
| sclk_i | input | 1 | Host serial clock; data advances on its falling edges |
| mode_3w_i | input | 1 | 1 = three-wire option with busy marker, 0 = plain option |
| result_i | input | WIDTH | Result word from the stand-in conversion engine, captured at conversion end |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data drive enable; 0 means the line is in high impedance |
| conv_done_o | output | 1 | Set when a conversion ends, cleared when the next one starts |

## Verification
A serial-clock falling edge and the end of a conversion can land on the same clock edge. The bench provokes this by dropping the serial clock so that its fall is sampled exactly at the end edge of the conversion. It then expects the busy marker, not a data bit, in the next cycle, and the MSB on the following falling edge. The bench also raises select partway through a read. It expects the line to be released at once, and a fresh conversion to run to its full length before the next word is read.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CONV,
        PH_READY,
        PH_SHIFT
    } phase_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_BUSYBIT,
        OP_MSB,
        OP_SHIFT,
        OP_OFF
    } sh_op_e;

endpackage

// File: rtl/adc_in_sampler.sv
module adc_in_sampler #(
    parameter int          NUM     = 2,
    parameter logic [NUM-1:0] RST_VAL = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] sig_i,
    output logic [NUM-1:0] prev_o
);

    for (genvar gi = 0; gi < NUM; gi++) begin : g_bit
        logic prev_d;
        logic prev_q;

        always_comb begin
            prev_d = sig_i[gi];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= RST_VAL[gi];
            else        prev_q <= prev_d;
        end

        assign prev_o[gi] = prev_q;
    end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CONV_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic end_o,
    output logic done_o
);

    localparam int CW = $clog2(CONV_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        end_o = st_q.busy && (st_q.cnt == '0);
        if (end_o) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.cnt  = CW'(CONV_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter
    import adc_port_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int CNTW = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sh_op_e           op_i,
    input  logic [WIDTH-1:0] word_i,
    output logic             sdo_o,
    output logic             oe_o,
    output logic             last_o,
    output logic [CNTW-1:0]  cnt_o
);

    typedef struct packed {
        logic [WIDTH-1:0] sh;
        logic [CNTW-1:0]  cnt;
        logic             sdo;
        logic             oe;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_LOAD: begin
                st_d.sh  = word_i;
                st_d.cnt = '0;
                st_d.sdo = 1'b0;
                st_d.oe  = 1'b0;
            end
            OP_BUSYBIT: begin
                st_d.sh  = word_i;
                st_d.cnt = '0;
                st_d.sdo = 1'b0;
                st_d.oe  = 1'b1;
            end
            OP_MSB: begin
                st_d.sdo = st_q.sh[WIDTH-1];
                st_d.sh  = st_q.sh << 1;
                st_d.cnt = CNTW'(1);
                st_d.oe  = 1'b1;
            end
            OP_SHIFT: begin
                if (st_q.cnt == CNTW'(WIDTH)) begin
                    st_d.oe = 1'b0;
                end else begin
                    st_d.sdo = st_q.sh[WIDTH-1];
                    st_d.sh  = st_q.sh << 1;
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            OP_OFF: begin
                st_d.oe = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o  = st_q.sdo;
    assign oe_o   = st_q.oe;
    assign last_o = (st_q.cnt == CNTW'(WIDTH));
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int CONV_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_sel_i,
    input  logic             sclk_i,
    input  logic             mode_3w_i,
    input  logic [WIDTH-1:0] result_i,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    output logic             conv_done_o
);

    localparam int CNTW   = $clog2(WIDTH + 1);
    localparam int IDX_SEL  = 0;
    localparam int IDX_SCLK = 1;

    logic [1:0]      raw_in;
    logic [1:0]      prev_in;
    logic            sel_rise, sel_fall, sclk_fall;
    logic            conv_busy, conv_end, conv_start;
    logic            sh_last;
    logic [CNTW-1:0] bit_cnt;
    sh_op_e          sh_op;

    typedef struct packed {
        phase_e phase;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    assign raw_in = {sclk_i, conv_sel_i};

    adc_in_sampler #(
        .NUM     (2),
        .RST_VAL (2'b11)
    ) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (raw_in),
        .prev_o (prev_in)
    );

    assign sel_rise  = conv_sel_i & ~prev_in[IDX_SEL];
    assign sel_fall  = ~conv_sel_i & prev_in[IDX_SEL];
    assign sclk_fall = ~sclk_i & prev_in[IDX_SCLK];
    assign conv_start = sel_rise & ~conv_busy;

    adc_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sel_rise),
        .busy_o  (conv_busy),
        .end_o   (conv_end),
        .done_o  (conv_done_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        sh_op = OP_HOLD;
        if (conv_end) begin
            if (mode_3w_i && !conv_sel_i) begin
                sh_op       = OP_BUSYBIT;
                ctl_d.phase = PH_SHIFT;
            end else begin
                sh_op       = OP_LOAD;
                ctl_d.phase = PH_READY;
            end
        end else if (conv_start) begin
            sh_op       = OP_OFF;
            ctl_d.phase = PH_CONV;
        end else if (sel_rise) begin
            sh_op = OP_OFF;
        end else begin
            unique case (ctl_q.phase)
                PH_READY: begin
                    if (!mode_3w_i && sel_fall) begin
                        sh_op       = OP_MSB;
                        ctl_d.phase = PH_SHIFT;
                    end
                end
                PH_SHIFT: begin
                    if (sclk_fall && !conv_sel_i) begin
                        sh_op = OP_SHIFT;
                        if (sh_last) ctl_d.phase = PH_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_IDLE};
        else        ctl_q <= ctl_d;
    end

    adc_bit_shifter #(
        .WIDTH (WIDTH)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (sh_op),
        .word_i (result_i),
        .sdo_o  (sdo_o),
        .oe_o   (sdo_oe_o),
        .last_o (sh_last),
        .cnt_o  (bit_cnt)
    );

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
    parameter int WIDTH = 16,
    localparam int CNTW = $clog2(WIDTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_sel_i,
    input logic            mode_3w_i,
    input logic            sdo_o,
    input logic            sdo_oe_o,
    input logic            conv_done_o,
    input logic            conv_busy,
    input logic [CNTW-1:0] bit_cnt
);

    AST_HIZ_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> !sdo_oe_o); // R1

    AST_DONE_CLEAR_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> !conv_done_o); // R1

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_done_o) |-> $past(conv_busy)); // R2

    AST_BUSY_MARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sdo_oe_o) && $past(mode_3w_i)) |-> !sdo_o); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNTW'(WIDTH)); // R4

    AST_RELEASE_ON_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && $rose(conv_sel_i)) |=> !sdo_oe_o); // R6

    AST_QUIET_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_sel_i && $past(conv_sel_i)) |-> !sdo_oe_o); // R8

endmodule

bind adc_serial_port adc_serial_port_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_sel_i  (conv_sel_i),
    .mode_3w_i   (mode_3w_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .conv_done_o (conv_done_o),
    .conv_busy   (conv_busy),
    .bit_cnt     (bit_cnt)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;

    localparam int W   = 16;
    localparam int N   = 8;
    localparam int NV  = 6;

    typedef struct packed {
        logic         mode;
        logic [W-1:0] word;
        logic [4:0]   cut;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{mode: 1'b1, word: 16'hA5C3, cut: 5'd0},
        '{mode: 1'b0, word: 16'h8001, cut: 5'd0},
        '{mode: 1'b1, word: 16'hFFFF, cut: 5'd0},
        '{mode: 1'b0, word: 16'h7FFE, cut: 5'd0},
        '{mode: 1'b1, word: 16'h1234, cut: 5'd5},
        '{mode: 1'b0, word: 16'hC0DE, cut: 5'd3}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel = 1'b1;
    logic         sclk = 1'b1;
    logic         mode = 1'b0;
    logic [W-1:0] word = '0;
    logic         sdo, oe, done;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    adc_serial_port #(
        .WIDTH       (W),
        .CONV_CYCLES (N)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_sel_i  (sel),
        .sclk_i      (sclk),
        .mode_3w_i   (mode),
        .result_i    (word),
        .sdo_o       (sdo),
        .sdo_oe_o    (oe),
        .conv_done_o (done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse();
        sclk = 1'b0;
        step();
    endtask

    task automatic pulse_end();
        sclk = 1'b1;
        step();
    endtask

    // Rise of select; returns at the negedge just after the start edge.
    task automatic start_conv();
        sel = 1'b0;
        step();
        sel = 1'b1;
        step();
    endtask

    task automatic drain();
        sel  = 1'b1;
        sclk = 1'b1;
        steps(N + 4);
    endtask

    task automatic run_vec(input vec_t v);
        int nb;
        mode = v.mode;
        word = v.word;
        start_conv();
        if (v.mode) sel = 1'b0;
        steps(N - 1);
        chk("R1", "oe before end", oe, 1'b0);
        chk("R1", "done before end", done, 1'b0);
        step();
        chk("R1", "done at end", done, 1'b1);
        if (v.mode) begin
            chk("R3", "busy oe", oe, 1'b1);
            chk("R3", "busy bit", sdo, 1'b0);
            nb = W;
        end else begin
            chk("R5", "oe before sel fall", oe, 1'b0);
            sel = 1'b0;
            step();
            chk("R5", "msb oe", oe, 1'b1);
            chk("R5", "msb", sdo, v.word[W-1]);
            nb = W - 1;
        end
        for (int k = 1; k <= nb; k++) begin
            if (v.cut != 0 && k > int'(v.cut)) break;
            pulse();
            if (v.mode) chk("R4", "bit", sdo, v.word[W-k]);
            else        chk("R5", "bit", sdo, v.word[W-1-k]);
            pulse_end();
        end
        if (v.cut == 0) begin
            pulse();
            if (v.mode) chk("R4", "release after edge 17", oe, 1'b0);
            else        chk("R5", "release after edge 16", oe, 1'b0);
            pulse_end();
        end else begin
            sel = 1'b1;
            step();
            chk("R6", "release on select rise", oe, 1'b0);
        end
        drain();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        steps(3);
        chk("R1", "reset oe", oe, 1'b0);
        chk("R1", "reset done", done, 1'b0);
        rst_n = 1'b1;
        steps(2);
        chk("R1", "idle oe", oe, 1'b0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R2: select toggles during conversion leave its length unchanged
        mode = 1'b1; word = 16'h9C35;
        start_conv();
        sel = 1'b0; step();
        sel = 1'b1; step();
        sel = 1'b0; step();
        steps(N - 4);
        chk("R2", "oe one cycle before end", oe, 1'b0);
        step();
        chk("R2", "busy marker on time", oe, 1'b1);
        chk("R2", "busy bit", sdo, 1'b0);
        pulse();
        chk("R2", "msb", sdo, 1'b1);
        pulse_end();
        drain();

        // R7: serial-clock falls during conversion and at the end edge are ignored
        mode = 1'b1; word = 16'h4B2D;
        start_conv();
        sel = 1'b0;
        pulse(); pulse_end();
        pulse(); pulse_end();
        steps(N - 5);
        sclk = 1'b0;
        step();
        chk("R7", "oe at end with coincident fall", oe, 1'b1);
        chk("R7", "busy bit kept", sdo, 1'b0);
        pulse_end();
        pulse();
        chk("R7", "first bit is msb", sdo, word[W-1]);
        pulse_end();
        pulse();
        chk("R7", "second bit", sdo, word[W-2]);
        pulse_end();
        drain();

        // R8: select high at end in three-wire mode gives no busy marker
        mode = 1'b1; word = 16'h0F0F;
        start_conv();
        steps(N);
        chk("R8", "no marker", oe, 1'b0);
        pulse(); pulse_end();
        chk("R8", "edge with select high", oe, 1'b0);
        sel = 1'b0; step();
        chk("R8", "select fall", oe, 1'b0);
        pulse();
        chk("R8", "edge with select low", oe, 1'b0);
        pulse_end();
        drain();

        // R7 and R9: plain mode, edges with select high ignored; held-low clock moves one bit
        mode = 1'b0; word = 16'hB3A7;
        start_conv();
        steps(N);
        for (int k = 0; k < 3; k++) begin
            pulse(); pulse_end();
        end
        chk("R7", "oe with select high", oe, 1'b0);
        sel = 1'b0; step();
        chk("R7", "msb after ignored edges", sdo, word[W-1]);
        pulse();
        chk("R7", "bit 14 not skipped", sdo, word[W-2]);
        steps(3);
        chk("R9", "held low keeps bit", sdo, word[W-2]);
        pulse_end();
        pulse();
        chk("R9", "next bit", sdo, word[W-3]);
        pulse_end();
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule